// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the interrupt phase that closes each instruction cycle. The execute logic signals an instruction boundary. At that boundary the sequencer checks whether a request is pending and interrupts are enabled. If either is false, it releases the next instruction fetch in the same cycle and adds no latency.

If both are true, it takes the interrupt and issues two bus transactions through its memory address and memory buffer registers. First it writes the current program counter to the stack. The stack pointer is decremented by one word before this write, so the stack grows downward. Then it reads the vector-table word for the requesting source and hands that word to the program counter. The fetch that follows runs from the first handler instruction.

The enable bit and the PC and SP registers live outside the block. The sequencer tells them when to update through single-cycle load pulses. The memory port is a simple strobe/ready pair: a strobe stays high, with address and data steady, until ready is sampled high.

Top module: `irq_entry_seq`

## Requirements
- R1: When `boundary_i` is high with the sequencer idle and either `irq_pend_i` or `ie_i` low, `fetch_go_o` is high in that same cycle. In that case no memory strobe rises, `ie_clr_o` stays low and `busy_o` stays low.
- R2: When `boundary_i`, `irq_pend_i` and `ie_i` are all high with the sequencer idle, `ie_clr_o` and `sp_load_o` pulse in that cycle. `sp_new_o` equals `sp_i - WORD_BYTES`, modulo 2^W.
- R3: In the cycle after entry, `mem_we_o` is high. `mem_addr_o` is the decremented SP and `mem_wdata_o` is the PC sampled at entry.
- R4: The cycle after the write is accepted, `mem_re_o` is high with `mem_addr_o = VEC_BASE + src * WORD_BYTES` (modulo 2^W). Here src is the source ID sampled at entry.
- R5: The stack write always precedes the vector read, and `mem_we_o` and `mem_re_o` are never high together.
- R6: The cycle after the read is accepted, `pc_load_o` and `fetch_go_o` pulse together with `pc_new_o` equal to the word read. The sequencer then returns to idle.
- R7: While the sequence runs (`busy_o` high), `boundary_i` and changes on `irq_src_i` are ignored. No second entry occurs and the vector address does not change.
- R8: After reset, the sequencer is idle with `busy_o`, both strobes and all pulses low.
- R9: A strobe held without ready stays high with a steady address and data. With a wait of w cycles per access, the handler fetch is released 2w+3 cycles after entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | End of execute phase, instruction boundary |
| irq_pend_i | input | 1 | Interrupt request pending |
| irq_src_i | input | SRC_W | Requesting source ID |
| ie_i | input | 1 | Interrupt enable bit |
| ie_clr_o | output | 1 | Pulse: clear the enable bit |
| pc_i | input | W | Current program counter |
| pc_load_o | output | 1 | Pulse: load `pc_new_o` into PC |
| pc_new_o | output | W | Handler address |
| sp_i | input | W | Current stack pointer |
| sp_load_o | output | 1 | Pulse: load `sp_new_o` into SP |
| sp_new_o | output | W | Decremented stack pointer |
| mem_addr_o | output | W | Memory address (from MAR) |
| mem_wdata_o | output | W | Memory write data (from MBR) |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| mem_rdata_i | input | W | Memory read data |
| mem_rdy_i | input | 1 | Memory transaction accepted |
| fetch_go_o | output | 1 | Proceed to instruction fetch |
| busy_o | output | 1 | Interrupt sequence in progress |

## Verification
The hardest situation to reach from the ports is a second boundary, with a different source ID, arriving while the sequencer is stalled mid-sequence on a slow memory. The bench gets there by stretching every access with a programmable number of wait cycles. In the first cycle of the stack write it raises a new boundary and changes the source. A scoreboard then confirms that the vector read still uses the source captured at entry and that no extra transactions appear. Wraparound of the stack pointer below zero and a back-to-back entry right after a completed sequence cover the remaining edges.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_VEC  = 2'd2,
    ST_LOAD = 2'd3
  } seq_state_t;
endpackage

// File: rtl/irq_gate.sv
// Boundary decision: take the interrupt or pass straight to fetch.
module irq_gate (
  input  logic boundary_i,
  input  logic busy_i,
  input  logic pend_i,
  input  logic ie_i,
  output logic take_o,
  output logic pass_o
);
  logic at_idle_boundary;
  assign at_idle_boundary = boundary_i & ~busy_i;
  assign take_o = at_idle_boundary & pend_i & ie_i;
  assign pass_o = at_idle_boundary & ~(pend_i & ie_i);
endmodule

// File: rtl/irq_fsm.sv
// Orders the stack write, vector read and PC hand-off.
module irq_fsm
  import irq_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic rdy_i,
  output logic we_o,
  output logic re_o,
  output logic load_o,
  output logic busy_o,
  output logic save_done_o,
  output logic vec_done_o
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take_i) state_d = ST_SAVE;
      ST_SAVE: if (rdy_i)  state_d = ST_VEC;
      ST_VEC:  if (rdy_i)  state_d = ST_LOAD;
      ST_LOAD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign we_o        = (state_q == ST_SAVE);
  assign re_o        = (state_q == ST_VEC);
  assign load_o      = (state_q == ST_LOAD);
  assign busy_o      = (state_q != ST_IDLE);
  assign save_done_o = we_o & rdy_i;
  assign vec_done_o  = re_o & rdy_i;
endmodule

// File: rtl/irq_datapath.sv
// MAR, MBR and the captured source, plus the address arithmetic.
module irq_datapath #(
  parameter int W          = 16,
  parameter int SRC_W      = 3,
  parameter int WORD_BYTES = 2,
  parameter logic [W-1:0] VEC_BASE = 16'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             save_done_i,
  input  logic             vec_done_i,
  input  logic [W-1:0]     pc_i,
  input  logic [W-1:0]     sp_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [W-1:0]     rdata_i,
  output logic [W-1:0]     sp_next_o,
  output logic [W-1:0]     mar_o,
  output logic [W-1:0]     mbr_o
);
  localparam logic [W-1:0] STEP = W'(WORD_BYTES);

  function automatic logic [W-1:0] push_addr(input logic [W-1:0] sp);
    return sp - STEP;
  endfunction

  function automatic logic [W-1:0] vec_addr(input logic [SRC_W-1:0] src);
    return VEC_BASE + (W'(src) * STEP);
  endfunction

  logic [SRC_W-1:0] src_q;

  assign sp_next_o = push_addr(sp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_o <= '0;
      mbr_o <= '0;
      src_q <= '0;
    end else if (take_i) begin
      mar_o <= sp_next_o;
      mbr_o <= pc_i;
      src_q <= src_i;
    end else if (save_done_i) begin
      mar_o <= vec_addr(src_q);
    end else if (vec_done_i) begin
      mbr_o <= rdata_i;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int W          = 16,
  parameter int SRC_W      = 3,
  parameter int WORD_BYTES = 2,
  parameter logic [W-1:0] VEC_BASE = 16'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary_i,
  input  logic             irq_pend_i,
  input  logic [SRC_W-1:0] irq_src_i,
  input  logic             ie_i,
  output logic             ie_clr_o,
  input  logic [W-1:0]     pc_i,
  output logic             pc_load_o,
  output logic [W-1:0]     pc_new_o,
  input  logic [W-1:0]     sp_i,
  output logic             sp_load_o,
  output logic [W-1:0]     sp_new_o,
  output logic [W-1:0]     mem_addr_o,
  output logic [W-1:0]     mem_wdata_o,
  output logic             mem_we_o,
  output logic             mem_re_o,
  input  logic [W-1:0]     mem_rdata_i,
  input  logic             mem_rdy_i,
  output logic             fetch_go_o,
  output logic             busy_o
);
  logic take, pass, load, save_done, vec_done;
  logic [W-1:0] mar, mbr;

  irq_gate u_gate (
    .boundary_i(boundary_i), .busy_i(busy_o), .pend_i(irq_pend_i),
    .ie_i(ie_i), .take_o(take), .pass_o(pass)
  );

  irq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .take_i(take), .rdy_i(mem_rdy_i),
    .we_o(mem_we_o), .re_o(mem_re_o), .load_o(load), .busy_o(busy_o),
    .save_done_o(save_done), .vec_done_o(vec_done)
  );

  irq_datapath #(.W(W), .SRC_W(SRC_W), .WORD_BYTES(WORD_BYTES), .VEC_BASE(VEC_BASE)) u_dp (
    .clk(clk), .rst_n(rst_n), .take_i(take), .save_done_i(save_done),
    .vec_done_i(vec_done), .pc_i(pc_i), .sp_i(sp_i), .src_i(irq_src_i),
    .rdata_i(mem_rdata_i), .sp_next_o(sp_new_o), .mar_o(mar), .mbr_o(mbr)
  );

  assign ie_clr_o    = take;
  assign sp_load_o   = take;
  assign mem_addr_o  = mar;
  assign mem_wdata_o = mbr;
  assign pc_new_o    = mbr;
  assign pc_load_o   = load;
  assign fetch_go_o  = pass | load;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int W          = 16,
  parameter int WORD_BYTES = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         boundary_i,
  input logic         irq_pend_i,
  input logic         ie_i,
  input logic         ie_clr_o,
  input logic [W-1:0] pc_i,
  input logic         pc_load_o,
  input logic [W-1:0] sp_i,
  input logic         sp_load_o,
  input logic [W-1:0] sp_new_o,
  input logic [W-1:0] mem_addr_o,
  input logic [W-1:0] mem_wdata_o,
  input logic         mem_we_o,
  input logic         mem_re_o,
  input logic         mem_rdy_i,
  input logic         fetch_go_o,
  input logic         busy_o
);
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !busy_o && !(irq_pend_i && ie_i)) |-> (fetch_go_o && !ie_clr_o)); // R1
  AST_SP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clr_o |-> (sp_load_o && sp_new_o == sp_i - W'(WORD_BYTES))); // R2
  AST_SAVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clr_o |=> (mem_we_o && mem_addr_o == $past(sp_new_o) && mem_wdata_o == $past(pc_i))); // R3
  AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && mem_rdy_i) |=> (mem_re_o && !mem_we_o)); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we_o, mem_re_o})); // R5
  AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re_o && mem_rdy_i) |=> (pc_load_o && fetch_go_o)); // R6
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ie_clr_o); // R7
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !mem_rdy_i) |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o))); // R9
  AST_RE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re_o && !mem_rdy_i) |=> (mem_re_o && $stable(mem_addr_o))); // R9
endmodule

bind irq_entry_seq irq_entry_chk #(.W(W), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .irq_pend_i(irq_pend_i),
  .ie_i(ie_i), .ie_clr_o(ie_clr_o), .pc_i(pc_i), .pc_load_o(pc_load_o),
  .sp_i(sp_i), .sp_load_o(sp_load_o), .sp_new_o(sp_new_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
  .mem_re_o(mem_re_o), .mem_rdy_i(mem_rdy_i), .fetch_go_o(fetch_go_o),
  .busy_o(busy_o)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  localparam int W = 16;
  localparam int SRC_W = 3;
  localparam int WB = 2;
  localparam logic [W-1:0] BASE = 16'h0100;

  logic clk = 0, rst_n = 0;
  logic boundary = 0, pend = 0, ie = 0;
  logic [SRC_W-1:0] src = '0;
  logic [W-1:0] pc = '0, sp = '0, rdata;
  logic rdy;
  logic ie_clr, pc_load, sp_load, we, re, fetch_go, busy;
  logic [W-1:0] pc_new, sp_new, addr, wdata;

  int checks = 0, errors = 0;
  int wait_n = 0, wcnt = 0;
  logic [33:0] expq[$];   // {kind[1:0], addr, data}: 0 write, 1 read, 2 pc load

  always #4 clk = ~clk;   // 125 MHz

  irq_entry_seq #(.W(W), .SRC_W(SRC_W), .WORD_BYTES(WB), .VEC_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .irq_pend_i(pend),
    .irq_src_i(src), .ie_i(ie), .ie_clr_o(ie_clr), .pc_i(pc),
    .pc_load_o(pc_load), .pc_new_o(pc_new), .sp_i(sp), .sp_load_o(sp_load),
    .sp_new_o(sp_new), .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we),
    .mem_re_o(re), .mem_rdata_i(rdata), .mem_rdy_i(rdy), .fetch_go_o(fetch_go),
    .busy_o(busy)
  );

  // memory model: content is a function of the address
  function automatic logic [W-1:0] mem_word(input logic [W-1:0] a);
    return a ^ 16'h5A3C;
  endfunction
  assign rdata = mem_word(addr);
  assign rdy = (we | re) && (wcnt >= wait_n);
  always @(posedge clk) begin
    if ((we | re) && !rdy) wcnt <= wcnt + 1;
    else wcnt <= 0;
  end

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare bus transactions and PC loads against the queue
  always @(negedge clk) begin
    #1;
    if (rst_n && ((we && rdy) || (re && rdy) || pc_load)) begin
      logic [1:0] k;
      logic [W-1:0] a, d;
      k = we ? 2'd0 : (re ? 2'd1 : 2'd2);
      if (expq.size() == 0) begin
        check(0, "R5 unexpected event", {14'd0, k}, 16'hFFFF);
      end else begin
        {k, a, d} = expq.pop_front();
        if (k == 2'd0) begin
          check(we && addr == a, "R3 write addr", addr, a);
          check(wdata == d, "R3 write data", wdata, d);
        end else if (k == 2'd1) begin
          check(re && addr == a, "R4 read addr", addr, a);
        end else begin
          check(pc_load && fetch_go && pc_new == d, "R6 pc load", pc_new, d);
        end
      end
    end
  end

  task automatic boundary_pass(input logic p, input logic e);
    @(negedge clk);
    boundary = 1; pend = p; ie = e; src = 3'd5;
    #1;
    check(fetch_go == 1, "R1 fetch same cycle", {15'd0, fetch_go}, 16'd1);
    check(!ie_clr && !we && !re && !busy, "R1 no entry",
          {12'd0, ie_clr, we, re, busy}, 16'd0);
    @(negedge clk);
    boundary = 0; pend = 0;
    #1;
    check(!we && !re && !busy, "R1 stays idle", {13'd0, we, re, busy}, 16'd0);
  endtask

  task automatic run_irq(input logic [SRC_W-1:0] s, input logic [W-1:0] p,
                         input logic [W-1:0] st, input int w, input bit disturb);
    logic [W-1:0] sa, va;
    int k;
    sa = st - W'(WB);
    va = BASE + W'(s) * W'(WB);
    wait_n = w;
    @(negedge clk);
    boundary = 1; pend = 1; ie = 1; src = s; pc = p; sp = st;
    #1;
    check(ie_clr && sp_load, "R2 pulses", {14'd0, ie_clr, sp_load}, 16'd3);
    check(sp_new == sa, "R2 sp decrement", sp_new, sa);
    check(!fetch_go, "R2 no fetch on entry", {15'd0, fetch_go}, 16'd0);
    expq.push_back({2'd0, sa, p});
    expq.push_back({2'd1, va, 16'h0000});
    expq.push_back({2'd2, 16'h0000, mem_word(va)});
    k = 0;
    while (k < 100) begin
      @(negedge clk);
      k++;
      boundary = 0;
      pc = ~p; sp = ~st;
      if (disturb && k == 1) begin
        boundary = 1; src = ~s;
      end
      #2;
      if (disturb && k == 1)
        check(busy && !ie_clr && !fetch_go, "R7 boundary ignored",
              {13'd0, busy, ie_clr, fetch_go}, 16'd4);
      if (fetch_go) break;
    end
    boundary = 0; pend = 0;
    check(k == 2 * w + 3, "R9 cycle count", W'(k), W'(2 * w + 3));
    check(expq.size() == 0, "R6 all events seen", W'(expq.size()), 16'd0);
    @(negedge clk);
    #2;
    check(!busy && !we && !re, "R6 back to idle", {13'd0, busy, we, re}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !we && !re && !pc_load && !ie_clr && !fetch_go, "R8 reset state",
          {10'd0, busy, we, re, pc_load, ie_clr, fetch_go}, 16'd0);
    rst_n = 1;
    boundary_pass(1'b0, 1'b1);
    boundary_pass(1'b1, 1'b0);
    boundary_pass(1'b0, 1'b0);
    run_irq(3'd3, 16'h1234, 16'h8000, 0, 0);
    run_irq(3'd7, 16'hBEEF, 16'h4000, 3, 1);
    run_irq(3'd0, 16'h0042, 16'h0000, 1, 0);  // SP wraps below zero
    run_irq(3'd6, 16'hFFFE, 16'h0010, 2, 1);  // immediately after previous
    boundary_pass(1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule